// File: doc/BRIEF.md
# Reset-Time Configuration Loader

After reset is released, this block configures a network interface once. In its first clock it captures two jumper strap inputs and an override-enable pin. Next it walks a fixed schedule of word addresses in a 16-bit-word Microwire serial EEPROM. It drives the chip select, serial clock and data-in lines and samples data-out.

Each word it fetches lands in an internal store. That store holds:

- the six-byte station address,
- a bus-width option bit,
- two signature words,
- the raw configuration words,
- a table of card information structure (CIS) bytes.

The store is filled whatever level the override pin had. Once the last word is in, the block checks the signatures. If the override pin was high at capture and both signatures match, the three configuration bytes from the EEPROM replace the strapped values. Otherwise the strapped values remain. A signature mismatch also raises an error flag. In every case a done flag rises and stays high until the next reset.

Top module: `boot_cfg_loader`

## Requirements
- R1: While rst_ni is low, done_o, sig_err_o, ee_cs_o, ee_sk_o, ee_di_o and all three configuration outputs are 0.
- R2: On the first rising clock after rst_ni goes high, cfg_a_o becomes {6'b0, strap_i} and cfg_b_o and cfg_c_o become 0. ee_override_i is captured on the same edge. Later changes on strap_i or ee_override_i have no effect.
- R3: ee_cs_o stays low during the capture cycle. EEPROM traffic starts only after it.
- R4: Each read frame runs with ee_cs_o high.
  - ee_di_o presents the bits 1, 1, 0 and then the AW address bits MSB first. ee_di_o changes only while ee_sk_o is low.
  - One dummy clock follows, then 16 data clocks. Data-out is sampled at the end of each high phase, MSB first.
  - Each ee_sk_o half period lasts HALF_DIV clocks.
  - ee_cs_o drops between frames.
- R5: Words are read in this order, each once: 00h, 01h, 02h, 03h, 07h, 08h, 0Eh, 0Fh, then 10h up to 10h+CIS_WORDS-1.
- R6: Station address byte k appears on mac_o[8k+7:8k]. Byte 2j comes from the low half of word j and byte 2j+1 from its high half, for j = 0..2.
- R7: bus8_o equals bit 0 of word 03h. The other bits of that word have no effect.
- R8: cis_byte_o for index i is the byte from word 10h + i/2: the low half when i is even, the high half when i is odd.
- R9: If the override was captured high and word 07h = 5757h and word 08h = 4242h, then after done:
  - cfg_a_o = word 0Eh[7:0],
  - cfg_b_o = word 0Eh[15:8],
  - cfg_c_o = word 0Fh[7:0].
- R10: If the override was captured low, the strapped configuration is kept. The store is still loaded.
- R11: On any signature mismatch, the strapped configuration is kept, sig_err_o goes to 1 and done_o still rises.
- R12: done_o rises after the last word is read and stays high, with ee_cs_o low from then on. The configuration outputs hold the strapped values until done_o rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| strap_i | input | 2 | Jumper strap levels (pulled high when open) |
| ee_override_i | input | 1 | EEPROM configuration override enable |
| ee_cs_o | output | 1 | EEPROM chip select |
| ee_sk_o | output | 1 | EEPROM serial clock |
| ee_di_o | output | 1 | Serial data to the EEPROM |
| ee_do_i | input | 1 | Serial data from the EEPROM |
| cis_idx_i | input | CIS_IW | CIS byte index |
| cis_byte_o | output | 8 | Selected CIS byte |
| mac_o | output | 48 | Station address, byte 0 in bits 7:0 |
| bus8_o | output | 1 | 8-bit bus enable |
| cfg_a_o | output | 8 | Configuration byte A |
| cfg_b_o | output | 8 | Configuration byte B |
| cfg_c_o | output | 8 | Configuration byte C |
| done_o | output | 1 | Load complete |
| sig_err_o | output | 1 | Signature mismatch |

## Verification
The hardest situation to reach is the one where the override was captured high, a signature is corrupted, and the pins move after capture. The strapped configuration must survive all of that while the store still fills.

The bench models the serial EEPROM at the pin level. It corrupts either signature word in selected runs. In other runs it inverts strap_i and ee_override_i one clock after capture. This shows whether the design re-reads the pins or commits the EEPROM configuration at the wrong time.

// File: rtl/bcl_pkg.sv
package bcl_pkg;

  typedef enum logic [2:0] {
    ST_CAPTURE,
    ST_ISSUE,
    ST_WAIT,
    ST_APPLY,
    ST_IDLE
  } ld_state_e;

  localparam logic [2:0]  MW_READ_CMD = 3'b110;
  localparam int unsigned STRAP_W     = 2;
  localparam int unsigned FIXED_WORDS = 8;
  localparam logic [15:0] SIG_LO      = 16'h5757;
  localparam logic [15:0] SIG_HI      = 16'h4242;

  localparam int unsigned ADDR_MAC0   = 0;
  localparam int unsigned ADDR_BUS    = 3;
  localparam int unsigned ADDR_SIG0   = 7;
  localparam int unsigned ADDR_SIG1   = 8;
  localparam int unsigned ADDR_CFG_AB = 14;
  localparam int unsigned ADDR_CFG_C  = 15;
  localparam int unsigned ADDR_CIS    = 16;

  // schedule index -> EEPROM word address; unused words are skipped
  function automatic int unsigned load_addr(input int unsigned idx);
    case (idx)
      0, 1, 2, 3: return idx;
      4:          return ADDR_SIG0;
      5:          return ADDR_SIG1;
      6:          return ADDR_CFG_AB;
      7:          return ADDR_CFG_C;
      default:    return ADDR_CIS + idx - FIXED_WORDS;
    endcase
  endfunction

endpackage

// File: rtl/bcl_halfdiv.sv
module bcl_halfdiv #(
  parameter int unsigned HALF_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/bcl_mw_reader.sv
module bcl_mw_reader
  import bcl_pkg::*;
#(
  parameter int unsigned AW       = 8,
  parameter int unsigned HALF_DIV = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  output logic          done_o,
  output logic [15:0]   data_o,
  output logic          cs_o,
  output logic          sk_o,
  output logic          di_o,
  input  logic          do_i
);
  localparam int unsigned CMD_BITS = 3 + AW;
  localparam int unsigned NB       = CMD_BITS + 17;
  localparam int unsigned BW       = $clog2(NB);
  localparam logic [BW-1:0] LAST_BIT   = BW'(NB - 1);
  localparam logic [BW-1:0] FIRST_DATA = BW'(CMD_BITS + 1);

  logic                busy_q, high_q, done_q;
  logic                cs_q, sk_q, di_q;
  logic [BW-1:0]       bc_q;
  logic [CMD_BITS-1:0] cmd_q;
  logic [CMD_BITS-1:0] cmd_w;
  logic [15:0]         data_q;
  logic                tick;

  assign cmd_w = {MW_READ_CMD, addr_i};

  bcl_halfdiv #(.HALF_DIV(HALF_DIV)) i_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (busy_q),
    .tick_o(tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      high_q <= 1'b0;
      done_q <= 1'b0;
      cs_q   <= 1'b0;
      sk_q   <= 1'b0;
      di_q   <= 1'b0;
      bc_q   <= '0;
      cmd_q  <= '0;
      data_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          cs_q   <= 1'b1;
          sk_q   <= 1'b0;
          high_q <= 1'b0;
          bc_q   <= '0;
          di_q   <= cmd_w[CMD_BITS-1];
          cmd_q  <= {cmd_w[CMD_BITS-2:0], 1'b0};
        end
      end else if (tick) begin
        if (!high_q) begin
          sk_q   <= 1'b1;
          high_q <= 1'b1;
        end else begin
          sk_q   <= 1'b0;
          high_q <= 1'b0;
          // sample at end of high phase; first clock after address is dummy
          if (bc_q >= FIRST_DATA) data_q <= {data_q[14:0], do_i};
          if (bc_q == LAST_BIT) begin
            busy_q <= 1'b0;
            cs_q   <= 1'b0;
            di_q   <= 1'b0;
            done_q <= 1'b1;
          end else begin
            bc_q  <= bc_q + 1'b1;
            di_q  <= cmd_q[CMD_BITS-1];
            cmd_q <= {cmd_q[CMD_BITS-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign done_o = done_q;
  assign data_o = data_q;
  assign cs_o   = cs_q;
  assign sk_o   = sk_q;
  assign di_o   = di_q;
endmodule

// File: rtl/bcl_store.sv
module bcl_store
  import bcl_pkg::*;
#(
  parameter int unsigned AW        = 8,
  parameter int unsigned CIS_WORDS = 8,
  parameter int unsigned CIS_IW    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [15:0]       wdata_i,
  input  logic [CIS_IW-1:0] cis_idx_i,
  output logic [47:0]       mac_o,
  output logic              bus8_o,
  output logic              sig_ok_o,
  output logic [15:0]       cfg_ab_o,
  output logic [7:0]        cfg_c_o,
  output logic [7:0]        cis_byte_o
);
  localparam int unsigned CIS_WW = CIS_IW - 1;

  logic [15:0] mac_w_q [3];
  logic [15:0] cis_q   [CIS_WORDS];
  logic [15:0] sig0_q, sig1_q, cfg_ab_q;
  logic [7:0]  cfg_c_q;
  logic        bus8_q;

  for (genvar j = 0; j < 3; j++) begin : g_mac
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mac_w_q[j] <= '0;
      else if (we_i && waddr_i == AW'(ADDR_MAC0 + j)) mac_w_q[j] <= wdata_i;
    end
  end

  for (genvar k = 0; k < CIS_WORDS; k++) begin : g_cis
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cis_q[k] <= '0;
      else if (we_i && waddr_i == AW'(ADDR_CIS + k)) cis_q[k] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sig0_q   <= '0;
      sig1_q   <= '0;
      cfg_ab_q <= '0;
      cfg_c_q  <= '0;
      bus8_q   <= 1'b0;
    end else if (we_i) begin
      if (waddr_i == AW'(ADDR_BUS))    bus8_q   <= wdata_i[0];
      if (waddr_i == AW'(ADDR_SIG0))   sig0_q   <= wdata_i;
      if (waddr_i == AW'(ADDR_SIG1))   sig1_q   <= wdata_i;
      if (waddr_i == AW'(ADDR_CFG_AB)) cfg_ab_q <= wdata_i;
      if (waddr_i == AW'(ADDR_CFG_C))  cfg_c_q  <= wdata_i[7:0];
    end
  end

  logic [CIS_WW-1:0] widx;
  logic [15:0]       cis_word;

  assign widx       = cis_idx_i[CIS_IW-1:1];
  assign cis_word   = (int'(widx) < CIS_WORDS) ? cis_q[widx] : 16'h0;
  assign cis_byte_o = cis_idx_i[0] ? cis_word[15:8] : cis_word[7:0];

  assign mac_o    = {mac_w_q[2], mac_w_q[1], mac_w_q[0]};
  assign bus8_o   = bus8_q;
  assign sig_ok_o = (sig0_q == SIG_LO) && (sig1_q == SIG_HI);
  assign cfg_ab_o = cfg_ab_q;
  assign cfg_c_o  = cfg_c_q;
endmodule

// File: rtl/boot_cfg_loader.sv
module boot_cfg_loader
  import bcl_pkg::*;
#(
  parameter int unsigned AW        = 8,
  parameter int unsigned CIS_WORDS = 8,
  parameter int unsigned HALF_DIV  = 4,
  localparam int unsigned CIS_IW   = $clog2(2 * CIS_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        strap_i,
  input  logic              ee_override_i,
  output logic              ee_cs_o,
  output logic              ee_sk_o,
  output logic              ee_di_o,
  input  logic              ee_do_i,
  input  logic [CIS_IW-1:0] cis_idx_i,
  output logic [7:0]        cis_byte_o,
  output logic [47:0]       mac_o,
  output logic              bus8_o,
  output logic [7:0]        cfg_a_o,
  output logic [7:0]        cfg_b_o,
  output logic [7:0]        cfg_c_o,
  output logic              done_o,
  output logic              sig_err_o
);
  localparam int unsigned N_WORDS = FIXED_WORDS + CIS_WORDS;
  localparam int unsigned IW      = $clog2(N_WORDS);
  localparam logic [IW-1:0] LAST_IDX = IW'(N_WORDS - 1);

  ld_state_e     state_q;
  logic [IW-1:0] idx_q;
  logic          ovr_q, done_q, err_q;
  logic [7:0]    cfg_a_q, cfg_b_q, cfg_c_q;

  logic          rd_start, rd_done, st_we, sig_ok;
  logic [AW-1:0] rd_addr;
  logic [15:0]   rd_data, ee_cfg_ab;
  logic [7:0]    ee_cfg_c;

  assign rd_addr  = AW'(load_addr(int'(idx_q)));
  assign rd_start = (state_q == ST_ISSUE);
  assign st_we    = (state_q == ST_WAIT) && rd_done;

  bcl_mw_reader #(.AW(AW), .HALF_DIV(HALF_DIV)) i_reader (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(rd_start),
    .addr_i (rd_addr),
    .done_o (rd_done),
    .data_o (rd_data),
    .cs_o   (ee_cs_o),
    .sk_o   (ee_sk_o),
    .di_o   (ee_di_o),
    .do_i   (ee_do_i)
  );

  bcl_store #(.AW(AW), .CIS_WORDS(CIS_WORDS), .CIS_IW(CIS_IW)) i_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (st_we),
    .waddr_i   (rd_addr),
    .wdata_i   (rd_data),
    .cis_idx_i (cis_idx_i),
    .mac_o     (mac_o),
    .bus8_o    (bus8_o),
    .sig_ok_o  (sig_ok),
    .cfg_ab_o  (ee_cfg_ab),
    .cfg_c_o   (ee_cfg_c),
    .cis_byte_o(cis_byte_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_CAPTURE;
      idx_q   <= '0;
      ovr_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      cfg_a_q <= '0;
      cfg_b_q <= '0;
      cfg_c_q <= '0;
    end else begin
      case (state_q)
        ST_CAPTURE: begin
          cfg_a_q <= {{(8-STRAP_W){1'b0}}, strap_i};
          cfg_b_q <= '0;
          cfg_c_q <= '0;
          ovr_q   <= ee_override_i;
          state_q <= ST_ISSUE;
        end
        ST_ISSUE: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (rd_done) begin
            if (idx_q == LAST_IDX) begin
              state_q <= ST_APPLY;
            end else begin
              idx_q   <= idx_q + 1'b1;
              state_q <= ST_ISSUE;
            end
          end
        end
        ST_APPLY: begin
          // commit only once both signatures are known
          if (sig_ok && ovr_q) begin
            cfg_a_q <= ee_cfg_ab[7:0];
            cfg_b_q <= ee_cfg_ab[15:8];
            cfg_c_q <= ee_cfg_c;
          end
          err_q   <= !sig_ok;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cfg_a_o   = cfg_a_q;
  assign cfg_b_o   = cfg_b_q;
  assign cfg_c_o   = cfg_c_q;
  assign done_o    = done_q;
  assign sig_err_o = err_q;
endmodule

// File: rtl/bcl_chk.sv
module bcl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       done_o,
  input logic       sig_err_o,
  input logic       ee_cs_o,
  input logic       ee_sk_o,
  input logic       ee_di_o,
  input logic [7:0] cfg_a_o,
  input logic [7:0] cfg_b_o,
  input logic [7:0] cfg_c_o
);
  // R12
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);

  // R12
  idle_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !ee_cs_o);

  // R4
  sk_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ee_cs_o |-> !ee_sk_o);

  // R4
  di_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ee_sk_o && $past(ee_sk_o)) |-> $stable(ee_di_o));

  // R11
  err_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sig_err_o |-> done_o);

  // R2
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ee_cs_o) && !done_o) |-> $stable({cfg_a_o, cfg_b_o, cfg_c_o}));
endmodule

bind boot_cfg_loader bcl_chk i_bcl_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .done_o   (done_o),
  .sig_err_o(sig_err_o),
  .ee_cs_o  (ee_cs_o),
  .ee_sk_o  (ee_sk_o),
  .ee_di_o  (ee_di_o),
  .cfg_a_o  (cfg_a_o),
  .cfg_b_o  (cfg_b_o),
  .cfg_c_o  (cfg_c_o)
);

// File: tb/test_boot_cfg_loader.sv
`timescale 1ns/1ps
module test_boot_cfg_loader;
  localparam int AW        = 8;
  localparam int CIS_WORDS = 8;
  localparam int HALF_DIV  = 4;
  localparam int CIS_IW    = 4;
  localparam int CMD       = 3 + AW;
  localparam int N_WORDS   = 8 + CIS_WORDS;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [1:0] strap_i = 2'b11;
  logic ee_override_i = 1'b0;
  logic ee_cs_o, ee_sk_o, ee_di_o;
  logic ee_do = 1'b0;
  logic [CIS_IW-1:0] cis_idx_i = '0;
  logic [7:0] cis_byte_o, cfg_a_o, cfg_b_o, cfg_c_o;
  logic [47:0] mac_o;
  logic bus8_o, done_o, sig_err_o;

  always #4 clk = ~clk;

  boot_cfg_loader #(.AW(AW), .CIS_WORDS(CIS_WORDS), .HALF_DIV(HALF_DIV)) i_boot_cfg_loader (
    .clk_i(clk), .rst_ni(rst_ni), .strap_i(strap_i), .ee_override_i(ee_override_i),
    .ee_cs_o(ee_cs_o), .ee_sk_o(ee_sk_o), .ee_di_o(ee_di_o), .ee_do_i(ee_do),
    .cis_idx_i(cis_idx_i), .cis_byte_o(cis_byte_o), .mac_o(mac_o), .bus8_o(bus8_o),
    .cfg_a_o(cfg_a_o), .cfg_b_o(cfg_b_o), .cfg_c_o(cfg_c_o),
    .done_o(done_o), .sig_err_o(sig_err_o)
  );

  int checks = 0;
  int fails = 0;

  // pin-level EEPROM model
  logic [15:0] ee_mem [256];
  int unsigned addr_q[$];
  int bad_cmd = 0;
  int edge_n = 0;
  int unsigned cur_addr = 0;
  logic [CMD-1:0] cmd_sh = '0;

  always @(posedge ee_sk_o) begin
    if (ee_cs_o) begin
      if (edge_n < CMD) begin
        cmd_sh = {cmd_sh[CMD-2:0], ee_di_o};
        if (edge_n == CMD - 1) begin
          if (cmd_sh[CMD-1 -: 3] != 3'b110) bad_cmd++;
          cur_addr = cmd_sh[AW-1:0];
          addr_q.push_back(cur_addr);
        end
      end else if (edge_n == CMD) begin
        ee_do = 1'b0;
      end else if (edge_n < CMD + 17) begin
        ee_do = ee_mem[cur_addr][15 - (edge_n - CMD - 1)];
      end
      edge_n++;
    end
  end

  always @(negedge ee_cs_o) edge_n = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // per-clock reference state
  bit mon_on = 0;
  logic psk = 0, pcs = 0;
  int sk_cnt = 0;
  logic [7:0] exp_strap = '0;

  task automatic step();
    @(negedge clk);
    if (mon_on) begin
      sk_cnt++;
      if (ee_sk_o !== psk && ee_cs_o && pcs)
        chk(sk_cnt == HALF_DIV, "R4", "sk half period", sk_cnt, HALF_DIV);
      if (ee_sk_o !== psk || ee_cs_o !== pcs) sk_cnt = 0;
      psk = ee_sk_o;
      pcs = ee_cs_o;
      if (!done_o)
        chk({cfg_a_o, cfg_b_o, cfg_c_o} == {exp_strap, 16'h0}, "R12", "cfg before done",
            {cfg_a_o, cfg_b_o, cfg_c_o}, {exp_strap, 16'h0});
      else
        chk(!ee_cs_o, "R12", "cs after done", ee_cs_o, 0);
    end
  endtask

  task automatic run_case(input logic [1:0] strap, input logic ovr, input logic b8,
                          input int bad_sig, input logic [15:0] seed, input bit flip);
    logic [47:0] exp_mac;
    logic [23:0] exp_cfg;
    bit sig_ok;
    int cyc;
    for (int i = 0; i < 256; i++) ee_mem[i] = 16'(i * 16'h0b3d) ^ seed;
    ee_mem[7] = 16'h5757;
    ee_mem[8] = 16'h4242;
    ee_mem[3] = (ee_mem[3] | 16'h00fe) & 16'hfffe | {15'h0, b8};  // R7 reserved bits set
    if (bad_sig == 1) ee_mem[8] = 16'h4243;
    if (bad_sig == 2) ee_mem[7] = 16'h5557;
    addr_q.delete();
    bad_cmd = 0;
    mon_on = 0;

    rst_ni = 1'b0;
    strap_i = strap;
    ee_override_i = ovr;
    repeat (3) @(negedge clk);
    // R1
    chk(!done_o && !sig_err_o && !ee_cs_o && !ee_sk_o && !ee_di_o, "R1", "flags in reset",
        {done_o, sig_err_o, ee_cs_o, ee_sk_o, ee_di_o}, 0);
    chk({cfg_a_o, cfg_b_o, cfg_c_o} == 24'h0, "R1", "cfg in reset", {cfg_a_o, cfg_b_o, cfg_c_o}, 0);

    rst_ni = 1'b1;
    exp_strap = {6'b0, strap};
    @(negedge clk);
    // R2 / R3
    chk({cfg_a_o, cfg_b_o, cfg_c_o} == {exp_strap, 16'h0}, "R2", "strap capture",
        {cfg_a_o, cfg_b_o, cfg_c_o}, {exp_strap, 16'h0});
    chk(!ee_cs_o, "R3", "cs in capture cycle", ee_cs_o, 0);
    if (flip) begin
      strap_i = ~strap;
      ee_override_i = ~ovr;
    end
    psk = ee_sk_o;
    pcs = ee_cs_o;
    sk_cnt = 0;
    mon_on = 1;
    cyc = 0;
    while (!done_o && cyc < 20000) begin
      step();
      cyc++;
    end
    chk(done_o, "R12", "done reached", done_o, 1);

    sig_ok = (bad_sig == 0);
    for (int k = 0; k < 6; k++)
      exp_mac[8*k +: 8] = (k % 2 == 0) ? ee_mem[k/2][7:0] : ee_mem[k/2][15:8];
    exp_cfg = (ovr && sig_ok) ? {ee_mem[14][7:0], ee_mem[14][15:8], ee_mem[15][7:0]}
                              : {exp_strap, 16'h0};
    chk(mac_o == exp_mac, "R6", "station address", mac_o, exp_mac);
    chk(bus8_o == b8, "R7", "bus width bit", bus8_o, b8);
    if (!ovr)
      chk({cfg_a_o, cfg_b_o, cfg_c_o} == exp_cfg, "R10", "override low keeps strap",
          {cfg_a_o, cfg_b_o, cfg_c_o}, exp_cfg);
    else if (!sig_ok)
      chk({cfg_a_o, cfg_b_o, cfg_c_o} == exp_cfg, "R11", "bad signature keeps strap",
          {cfg_a_o, cfg_b_o, cfg_c_o}, exp_cfg);
    else
      chk({cfg_a_o, cfg_b_o, cfg_c_o} == exp_cfg, "R9", "eeprom config applied",
          {cfg_a_o, cfg_b_o, cfg_c_o}, exp_cfg);
    chk(sig_err_o == !sig_ok, "R11", "signature error flag", sig_err_o, !sig_ok);
    chk(bad_cmd == 0, "R4", "read command bits", bad_cmd, 0);
    // R5
    chk(addr_q.size() == N_WORDS, "R5", "word count", addr_q.size(), N_WORDS);
    for (int i = 0; i < N_WORDS && i < addr_q.size(); i++) begin
      int unsigned ea;
      ea = (i < 4) ? i : (i == 4) ? 7 : (i == 5) ? 8 : (i == 6) ? 14 : (i == 7) ? 15 : 16 + i - 8;
      chk(addr_q[i] == ea, "R5", "word address order", addr_q[i], ea);
    end
    // R8
    for (int i = 0; i < 2 * CIS_WORDS; i++) begin
      logic [7:0] eb;
      cis_idx_i = CIS_IW'(i);
      #1;
      eb = (i % 2 == 0) ? ee_mem[16 + i/2][7:0] : ee_mem[16 + i/2][15:8];
      chk(cis_byte_o == eb, "R8", "cis byte", cis_byte_o, eb);
    end
    repeat (5) step();
    chk(done_o && !ee_cs_o, "R12", "done sticky", {done_o, ee_cs_o}, 2'b10);
    mon_on = 0;
  endtask

  initial begin
    run_case(2'b11, 1'b0, 1'b1, 0, 16'h1a2b, 0);
    run_case(2'b01, 1'b1, 1'b0, 0, 16'h6c3d, 1);
    run_case(2'b10, 1'b1, 1'b1, 1, 16'h0f0f, 0);
    run_case(2'b00, 1'b1, 1'b0, 2, 16'h9e37, 1);
    run_case(2'b01, 1'b0, 1'b1, 0, 16'h4d21, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule